// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block sits between a 16-bit synchronous host register port and up to four 8-bit NAND flash devices that share one data bus. Each host access to a register slot becomes one NAND bus cycle. Command writes, address writes, data writes and data reads each produce a single WE# or RE# pulse, with the command and address latch enables set to suit the cycle. The NAND byte always travels in the low 8 bits of the host word.

The host chooses a device by writing to one of the command slots. That write also asserts the chip enable of the chosen device, and the chip enable stays asserted through every later address and data cycle until the host writes to the release slot. One read slot stalls the host until the chosen device reports ready. Driver software uses it as a blocking wait for a program or erase operation to finish. Ordering commands and counting bytes are left to the host. The block has no buffering and no error correction.

Host protocol: the host holds `host_wr` or `host_rd`, with address and data, until it sees `host_wait` low at a rising clock edge. It then drops the strobe for at least one cycle.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset every `nand_ce_n` bit is 1, `nand_cle` and `nand_ale` are 0, `nand_we_n` and `nand_re_n` are 1, and `host_wait` is 0 while no access is requested.
- R2: A write to a command slot at byte offset 2*n (n from 0 to NUM_DEV-1) latches n as the selected device and drives `nand_ce_n[n]` low with all other chip enables high. It also performs a write cycle with `nand_cle` high, carrying `host_wdata[7:0]` on `nand_dq`. The high byte of the host data is ignored.
- R3: A write to offset 0x08 performs a write cycle with `nand_ale` high and `nand_cle` low, carrying `host_wdata[7:0]`, to the selected device. The chip enable is unchanged.
- R4: A write to offset 0x10 performs a write cycle with `nand_cle` and `nand_ale` both low. `nand_dq` is driven by the bridge only during write cycles.
- R5: A read of offset 0x10 performs an RE# cycle. The byte on `nand_dq` is sampled as RE# rises and is returned as `host_rdata` = {8'h00, byte} in the cycle in which `host_wait` falls.
- R6: In every strobe cycle the active strobe is low for PULSE_CLKS clocks and then high for HOLD_CLKS clocks while CLE/ALE hold their values. `host_wait` is high from the first request cycle through the hold period, which is 1+PULSE_CLKS+HOLD_CLKS cycles. It is low in the next cycle, when CLE and ALE are back at 0.
- R7: A read of offset 0x08 produces no strobe. It keeps `host_wait` high until `nand_rb` of the selected device is 1, and the ready lines of other devices have no effect. `host_wait` falls one cycle after the ready line is seen high. The read returns 0.
- R8: A write of any value to offset 0x0A completes with `host_wait` low in the request cycle, produces no strobe, and deasserts every chip enable from the next cycle.
- R9: An access to any other offset (the 0x0C and 0x0E slots, reads of command slots, odd byte offsets, offsets above 0x10) completes without wait and produces no NAND activity. A read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 5 | Byte offset of the register slot |
| host_wr | input | 1 | Write request, held until completion |
| host_rd | input | 1 | Read request, held until completion |
| host_wdata | input | 16 | Write data; low byte used |
| host_rdata | output | 16 | Read data |
| host_wait | output | 1 | Stall: access not yet complete |
| nand_dq | inout | 8 | Shared NAND data bus |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | NUM_DEV | Chip enables, active low, one per device |
| nand_rb | input | NUM_DEV | Ready/busy per device, 1 = ready |

## Verification
The hardest case to reach is the ready stall while a different device is the one that signals ready. The bench first selects a device with a command write. It then pulls every ready line low, issues the stalling read, and raises an unselected device's ready line in the middle of the stall. `host_wait` must stay high until the selected line rises, and it must fall exactly one cycle later. A second hard case is a device switch without a release write in between. A command write to another slot while a chip enable is latched must move the enable rather than add a second one.

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge #(
  parameter int NUM_DEV    = 4,
  parameter int PULSE_CLKS = 2,
  parameter int HOLD_CLKS  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               host_wait,
  inout  wire  [7:0]         nand_dq,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [NUM_DEV-1:0] nand_ce_n,
  input  logic [NUM_DEV-1:0] nand_rb
);
  localparam int MAXC = (PULSE_CLKS > HOLD_CLKS) ? PULSE_CLKS : HOLD_CLKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CLKS - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HOLD, S_RDY, S_DONE} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  sel;
  logic        ce_on, cle_q, ale_q, rd_q;
  logic [7:0]  wbyte, rbyte;

  logic [3:0] widx;
  logic       even, is_cmd, is_adr, is_term, is_dat, req, go_strobe, go_rdy, in_cyc;

  assign widx      = host_addr[4:1];
  assign even      = ~host_addr[0];
  assign is_cmd    = even && widx[3:2] == 2'b00 && int'(widx[1:0]) < NUM_DEV;
  assign is_adr    = even && widx == 4'd4;
  assign is_term   = even && widx == 4'd5;
  assign is_dat    = even && widx == 4'd8;
  assign req       = host_wr | host_rd;
  assign go_strobe = (host_wr & (is_cmd | is_adr | is_dat)) | (host_rd & is_dat);
  assign go_rdy    = host_rd & is_adr;
  assign in_cyc    = (st == S_LOW) || (st == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sel <= '0; ce_on <= 1'b0;
      cle_q <= 1'b0; ale_q <= 1'b0; rd_q <= 1'b0;
      wbyte <= '0; rbyte <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_strobe) begin
            st    <= S_LOW;
            cnt   <= '0;
            cle_q <= host_wr & is_cmd;
            ale_q <= host_wr & is_adr;
            rd_q  <= host_rd;
            wbyte <= host_wdata[7:0];
            if (host_wr & is_cmd) begin
              sel   <= widx[1:0];
              ce_on <= 1'b1;
            end
          end else if (go_rdy) begin
            st <= S_RDY;
          end else if (host_wr & is_term) begin
            ce_on <= 1'b0;
          end
        end
        S_LOW: begin
          if (cnt == PULSE_LAST) begin
            st  <= S_HOLD;
            cnt <= '0;
            if (rd_q) rbyte <= nand_dq;
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (cnt == HOLD_LAST) begin
            st  <= S_DONE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RDY:  if (nand_rb[sel]) st <= S_DONE;
        default: begin
          st <= S_IDLE; cle_q <= 1'b0; ale_q <= 1'b0; rd_q <= 1'b0;
        end
      endcase
    end
  end

  assign nand_cle   = cle_q & in_cyc;
  assign nand_ale   = ale_q & in_cyc;
  assign nand_we_n  = ~((st == S_LOW) & ~rd_q);
  assign nand_re_n  = ~((st == S_LOW) & rd_q);
  assign nand_dq    = (in_cyc & ~rd_q) ? wbyte : 8'hzz;
  assign host_wait  = (st == S_IDLE) ? (go_strobe | go_rdy) : (st != S_DONE);
  assign host_rdata = (host_rd & is_dat) ? {8'h00, rbyte} : 16'h0000;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_ce
    assign nand_ce_n[i] = ~(ce_on && int'(sel) == i);
  end

  assert_ce_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));
  assert_cmd_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && host_wr && is_cmd) |=> (!nand_ce_n[sel] && nand_cle && !nand_we_n));
  assert_rdy_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDY && !nand_rb[sel]) |=> host_wait);
  assert_term_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && host_wr && is_term) |=> (&nand_ce_n));
  assert_null_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req && !go_strobe && !go_rdy) |-> (!host_wait ##1 (nand_we_n && nand_re_n)));
  assert_latch_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> ($stable(nand_cle) && $stable(nand_ale)));
endmodule

// File: tb/tb_nand_bus_bridge.sv
module tb_nand_bus_bridge;
  localparam int N = 4, P = 3, H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_wait;
  wire  [7:0]  nand_dq;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [N-1:0] nand_ce_n;
  logic [N-1:0] nand_rb = '1;
  logic [7:0]  dev_byte = 8'h00;

  int checks = 0, fails = 0;
  int cur_ce = -1;

  always #5 clk = ~clk;

  assign nand_dq = (!nand_re_n) ? dev_byte : 8'hzz;

  nand_bus_bridge #(.NUM_DEV(N), .PULSE_CLKS(P), .HOLD_CLKS(H)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .nand_dq(nand_dq), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_ce_n(nand_ce_n), .nand_rb(nand_rb));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_ce();
    return (cur_ce < 0) ? '1 : ~(N'(1) << cur_ce);
  endfunction

  // pins = {wait, we_n, re_n, cle, ale, ce_n}
  task automatic pins(input string rq, input bit w, input bit we, input bit re, input bit c, input bit a);
    logic [N+4:0] act, exp;
    act = {host_wait, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_ce_n};
    exp = {w, we, re, c, a, exp_ce()};
    chk(act === exp, rq, "pins {wait,we_n,re_n,cle,ale,ce_n}", int'(act), int'(exp));
  endtask

  task automatic strobe_acc(input logic [4:0] a, input bit wr, input logic [15:0] wd,
                            input bit c, input bit al, input string rq);
    @(negedge clk);
    host_addr = a; host_wr = wr; host_rd = !wr; host_wdata = wd;
    #1 pins({rq, " R6 request"}, 1, 1, 1, 0, 0);
    if (wr && a[4:3] == 2'b00) cur_ce = int'(a[2:1]);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      pins({rq, " R6 strobe low"}, 1, !wr, wr, c, al);
      if (wr) chk(nand_dq === wd[7:0], rq, "dq byte", int'(nand_dq), int'(wd[7:0]));
    end
    for (int i = 0; i < H; i++) begin
      @(negedge clk);
      pins({rq, " R6 hold"}, 1, 1, 1, c, al);
      if (wr) chk(nand_dq === wd[7:0], {rq, " R4"}, "dq held", int'(nand_dq), int'(wd[7:0]));
    end
    @(negedge clk);
    pins({rq, " R6 done"}, 0, 1, 1, 0, 0);
    if (!wr) chk(host_rdata === {8'h00, dev_byte}, "R5", "read data", int'(host_rdata), int'({8'h00, dev_byte}));
    host_wr = 0; host_rd = 0;
  endtask

  task automatic quick_acc(input logic [4:0] a, input bit wr, input logic [15:0] wd, input string rq);
    @(negedge clk);
    host_addr = a; host_wr = wr; host_rd = !wr; host_wdata = wd;
    #1 pins({rq, " no wait"}, 0, 1, 1, 0, 0);
    if (!wr) chk(host_rdata === 16'h0, rq, "read zero", int'(host_rdata), 0);
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    if (wr && a == 5'h0A) cur_ce = -1;
    #1 pins({rq, " after"}, 0, 1, 1, 0, 0);
  endtask

  task automatic ready_wait(input int delay, input int other);
    @(negedge clk);
    nand_rb = '0;
    host_addr = 5'h08; host_rd = 1; host_wr = 0;
    #1 pins("R7 request", 1, 1, 1, 0, 0);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      pins("R7 stalled", 1, 1, 1, 0, 0);
      if (i == 1) nand_rb[other] = 1'b1;
    end
    @(negedge clk);
    pins("R7 other ready ignored", 1, 1, 1, 0, 0);
    nand_rb[cur_ce] = 1'b1;
    @(negedge clk);
    pins("R7 released", 0, 1, 1, 0, 0);
    chk(host_rdata === 16'h0, "R7", "wait read data", int'(host_rdata), 0);
    host_rd = 0;
    nand_rb = '1;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pins("R1 reset", 0, 1, 1, 0, 0);

    strobe_acc(5'h02, 1, 16'hA570, 1, 0, "R2 cmd dev1");
    strobe_acc(5'h08, 1, 16'hFF12, 0, 1, "R3 addr");
    strobe_acc(5'h08, 1, 16'h0034, 0, 1, "R3 addr2");
    strobe_acc(5'h10, 1, 16'h125A, 0, 0, "R4 data wr");
    dev_byte = 8'hC3;
    strobe_acc(5'h10, 0, 16'h0000, 0, 0, "R5 data rd");
    ready_wait(4, 2);
    dev_byte = 8'h3C;
    strobe_acc(5'h10, 0, 16'h0000, 0, 0, "R5 data rd2");

    quick_acc(5'h0C, 1, 16'h00FF, "R9 slot 0C");
    quick_acc(5'h0E, 0, 16'h0000, "R9 slot 0E");
    quick_acc(5'h02, 0, 16'h0000, "R9 cmd read");
    quick_acc(5'h11, 1, 16'h0099, "R9 odd offset");
    quick_acc(5'h12, 0, 16'h0000, "R9 above data");

    quick_acc(5'h0A, 1, 16'h1234, "R8 release");
    repeat (2) begin @(negedge clk); pins("R1 idle", 0, 1, 1, 0, 0); end

    strobe_acc(5'h00, 1, 16'h00FF, 1, 0, "R2 cmd dev0");
    strobe_acc(5'h06, 1, 16'h0070, 1, 0, "R2 switch dev3");
    ready_wait(2, 0);
    quick_acc(5'h0A, 1, 16'h0000, "R8 release2");
    strobe_acc(5'h04, 1, 16'h0090, 1, 0, "R2 cmd dev2");
    dev_byte = 8'hA5;
    strobe_acc(5'h10, 0, 16'h0000, 0, 0, "R5 dev2 rd");
    quick_acc(5'h0A, 1, 16'h0000, "R8 release3");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule